// File: doc/BRIEF.md
# Frame-Synchronized Scanout Address Controller

This block holds the base and ceiling addresses that a display fetch engine reads while it scans out a frame. From a buffer origin, an extra byte offset, a line pitch, horizontal and vertical pan values, a pixel size in bytes and an active line count, it computes both addresses. It keeps them as one 64-bit register pair, so the fetch engine never sees a base from one flip together with a ceiling from another.

Only one flip may be in flight at a time. When a request arrives, the block estimates how close the next end of frame is. It takes the timestamp of the last end-of-frame pulse, counted with a free-running cycle counter, and adds a frame period given in cycles. If the time left is at least a programmable safety window, also in cycles, the new pair goes straight into the active register. Otherwise the pair is parked in a shadow register and copied across on the next end-of-frame pulse. A completion pulse marks the end of the frame that first scanned the new buffer. On the frame boundary where a parked pair is applied, no completion is given; it comes one frame later. Dropping the enable input abandons any flip that is parked or in flight.

Top module: `scanflip_top`

## Requirements
- R1: The base address (low 32 bits of `scan_pair`) equals origin + offset + y_pan × pitch + x_pan × pixel_bytes, modulo 2^32.
- R2: The ceiling address (high 32 bits of `scan_pair`) equals base + lines × pitch, minus one when parameter `CEIL_M1` is 1, modulo 2^32.
- R3: `scan_pair` is reset to zero. It changes only in one clock edge, in two cases: an accepted immediate flip, or the application of a parked flip. Both halves change in that same edge.
- R4: A request made while `flip_inflight` is 1 is rejected. `flip_busy` pulses high for one cycle in the next cycle, and `scan_pair`, `flip_pending` and `flip_inflight` stay as they were.
- R5: Let elapsed be the cycles from the last end-of-frame edge to the request edge. An accepted request with elapsed + window > period is parked: `flip_pending` rises and `scan_pair` is not changed.
- R6: An accepted request with elapsed + window ≤ period loads `scan_pair` in the edge that samples the request, and `flip_pending` stays 0.
- R7: A parked pair is copied into `scan_pair` at the next end-of-frame edge, with no `flip_done` pulse on that edge. `flip_done` pulses at the end-of-frame edge after that.
- R8: After an immediate flip, `flip_done` pulses for one cycle after the next end-of-frame edge, and `flip_inflight` drops to 0 at the same time.
- R9: Every end-of-frame edge records the cycle counter. Until the next such edge, the time left is measured from that stamp. A request made more than a frame period after the last stamp is therefore parked.
- R10: While `enable` is 0, `flip_pending` and `flip_inflight` are cleared, no `flip_done` fires, requests are ignored (no `flip_busy`, no state change), and a parked pair is dropped without reaching `scan_pair`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Flip logic enable; low abandons any flip |
| flip_req | input | 1 | One-cycle flip request, samples the geometry inputs |
| origin | input | 32 | Buffer origin address |
| offset | input | 32 | Extra byte offset into the buffer |
| pitch | input | 16 | Bytes per line |
| x_pan | input | 12 | Horizontal pan in pixels |
| y_pan | input | 12 | Vertical pan in lines |
| pix_bytes | input | 3 | Bytes per pixel |
| lines | input | 12 | Active line count |
| eof | input | 1 | End-of-frame pulse from the fetch engine |
| frame_period | input | 24 | Frame period in clock cycles |
| safe_window | input | 24 | Safety window before frame end, in cycles |
| scan_pair | output | 64 | Active {ceiling, base} address pair |
| flip_pending | output | 1 | A flip is parked in the shadow register |
| flip_inflight | output | 1 | A flip is accepted and not yet completed |
| flip_busy | output | 1 | One-cycle pulse: a request was rejected |
| flip_done | output | 1 | One-cycle pulse: flip completed |

## Verification
The bench places requests exactly at the deferral boundary, with elapsed + window equal to the period and one cycle past it. A design with an off-by-one in the comparison, or one that reads the counter before the timestamp register, would choose the wrong path at one of the two points. The bench also checks that the edge applying a parked pair gives no completion and that the next edge does. A design that signals completion early would hand the buffer back while it is still being scanned. Other cases: a request during an in-flight flip, a disable while a pair is parked (a leaky design would apply the stale pair on the next frame), a 32-bit address wrap, and a request made more than a frame after the last stamp.

// File: rtl/scanflip_pkg.sv
package scanflip_pkg;

  // Decision taken on a request edge
  typedef enum logic [1:0] {
    FLIP_IDLE   = 2'd0,
    FLIP_NOW    = 2'd1,
    FLIP_DEFER  = 2'd2,
    FLIP_REJECT = 2'd3
  } flip_act_e;

endpackage

// File: rtl/scanflip_addr.sv
module scanflip_addr #(
  parameter int AW      = 32,
  parameter int PW      = 16,
  parameter int PANW    = 12,
  parameter int LW      = 12,
  parameter int BW      = 3,
  parameter int CEIL_M1 = 0
) (
  input  logic [AW-1:0]   origin,
  input  logic [AW-1:0]   offset,
  input  logic [PW-1:0]   pitch,
  input  logic [PANW-1:0] x_pan,
  input  logic [PANW-1:0] y_pan,
  input  logic [BW-1:0]   pix_bytes,
  input  logic [LW-1:0]   lines,
  output logic [2*AW-1:0] pair
);

  localparam logic [AW-1:0] CEIL_ADJ = AW'(CEIL_M1);

  // R1: first byte fetched for the panned view
  function automatic logic [AW-1:0] base_of(
    input logic [AW-1:0] org, input logic [AW-1:0] off,
    input logic [PW-1:0] p, input logic [PANW-1:0] xp,
    input logic [PANW-1:0] yp, input logic [BW-1:0] bpp);
    base_of = org + off + AW'(yp) * AW'(p) + AW'(xp) * AW'(bpp);
  endfunction

  // R2: end of the active area
  function automatic logic [AW-1:0] ceil_of(
    input logic [AW-1:0] base, input logic [LW-1:0] n,
    input logic [PW-1:0] p);
    ceil_of = base + AW'(n) * AW'(p) - CEIL_ADJ;
  endfunction

  logic [AW-1:0] base_w;
  logic [AW-1:0] ceil_w;

  always_comb begin
    base_w = base_of(origin, offset, pitch, x_pan, y_pan, pix_bytes);
    ceil_w = ceil_of(base_w, lines, pitch);
    pair   = {ceil_w, base_w};
  end

endmodule

// File: rtl/scanflip_timer.sv
module scanflip_timer #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eof,
  input  logic [TW-1:0] frame_period,
  input  logic [TW-1:0] safe_window,
  output logic          near_end
);

  logic [TW-1:0] now_cnt;
  logic [TW-1:0] eof_stamp;
  logic [TW-1:0] elapsed;
  logic [TW:0]   reach;

  // R9: free-running time base and end-of-frame timestamp
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now_cnt   <= '0;
      eof_stamp <= '0;
    end else begin
      now_cnt <= now_cnt + 1'b1;
      if (eof) eof_stamp <= now_cnt;
    end
  end

  // time left = stamp + period - now ; near when time left < window
  always_comb begin
    elapsed  = now_cnt - eof_stamp;
    reach    = {1'b0, elapsed} + {1'b0, safe_window};
    near_end = reach > {1'b0, frame_period};
  end

endmodule

// File: rtl/scanflip_seq.sv
module scanflip_seq
  import scanflip_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          flip_req,
  input  logic          eof,
  input  logic          near_end,
  input  logic [DW-1:0] new_pair,
  output logic [DW-1:0] active_pair,
  output logic [DW-1:0] shadow_pair,
  output logic          pending,
  output logic          inflight,
  output logic          busy,
  output logic          done,
  output flip_act_e     act,
  output logic          apply_evt,
  output logic          done_evt
);

  always_comb begin
    if (!enable || !flip_req) act = FLIP_IDLE;
    else if (inflight)        act = FLIP_REJECT;
    else if (near_end)        act = FLIP_DEFER;
    else                      act = FLIP_NOW;
    apply_evt = enable && eof && pending;
    done_evt  = enable && eof && inflight && !pending;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_pair <= '0;
      shadow_pair <= '0;
      pending     <= 1'b0;
      inflight    <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
    end else begin
      busy <= (act == FLIP_REJECT);
      done <= done_evt;
      if (!enable) begin
        pending  <= 1'b0;
        inflight <= 1'b0;
      end else begin
        if (apply_evt) begin
          active_pair <= shadow_pair;
          pending     <= 1'b0;
        end
        if (done_evt) inflight <= 1'b0;
        case (act)
          FLIP_NOW: begin
            active_pair <= new_pair;
            inflight    <= 1'b1;
          end
          FLIP_DEFER: begin
            shadow_pair <= new_pair;
            pending     <= 1'b1;
            inflight    <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/scanflip_top.sv
module scanflip_top
  import scanflip_pkg::*;
#(
  parameter int AW      = 32,
  parameter int PW      = 16,
  parameter int PANW    = 12,
  parameter int LW      = 12,
  parameter int BW      = 3,
  parameter int TW      = 24,
  parameter int CEIL_M1 = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            flip_req,
  input  logic [AW-1:0]   origin,
  input  logic [AW-1:0]   offset,
  input  logic [PW-1:0]   pitch,
  input  logic [PANW-1:0] x_pan,
  input  logic [PANW-1:0] y_pan,
  input  logic [BW-1:0]   pix_bytes,
  input  logic [LW-1:0]   lines,
  input  logic            eof,
  input  logic [TW-1:0]   frame_period,
  input  logic [TW-1:0]   safe_window,
  output logic [2*AW-1:0] scan_pair,
  output logic            flip_pending,
  output logic            flip_inflight,
  output logic            flip_busy,
  output logic            flip_done
);

  localparam int DW = 2 * AW;

  logic [DW-1:0] new_pair;
  logic [DW-1:0] shadow_pair;
  logic          near_end;
  flip_act_e     act;
  logic          apply_evt;
  logic          done_evt;

  scanflip_addr #(
    .AW(AW), .PW(PW), .PANW(PANW), .LW(LW), .BW(BW), .CEIL_M1(CEIL_M1)
  ) u_addr (
    .origin(origin), .offset(offset), .pitch(pitch), .x_pan(x_pan),
    .y_pan(y_pan), .pix_bytes(pix_bytes), .lines(lines), .pair(new_pair)
  );

  scanflip_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .eof(eof), .frame_period(frame_period),
    .safe_window(safe_window), .near_end(near_end)
  );

  scanflip_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .flip_req(flip_req),
    .eof(eof), .near_end(near_end), .new_pair(new_pair),
    .active_pair(scan_pair), .shadow_pair(shadow_pair),
    .pending(flip_pending), .inflight(flip_inflight), .busy(flip_busy),
    .done(flip_done), .act(act), .apply_evt(apply_evt), .done_evt(done_evt)
  );

endmodule

// File: rtl/scanflip_chk.sv
module scanflip_chk
  import scanflip_pkg::*;
#(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          flip_req,
  input logic          eof,
  input logic          flip_busy,
  input logic          flip_done,
  input logic          flip_pending,
  input logic          flip_inflight,
  input logic [DW-1:0] scan_pair,
  input logic [DW-1:0] new_pair,
  input logic [DW-1:0] shadow_pair,
  input flip_act_e     act,
  input logic          apply_evt,
  input logic          done_evt
);

  assert_pair_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act != FLIP_NOW && !apply_evt) |=> $stable(scan_pair));

  assert_reject_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_req && enable && flip_inflight && !eof) |=>
      (flip_busy && $stable(scan_pair) && flip_inflight));

  assert_defer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == FLIP_DEFER) |=> (flip_pending && flip_inflight && $stable(scan_pair)));

  assert_now_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act == FLIP_NOW) |=> (scan_pair == $past(new_pair) && !flip_pending));

  assert_apply_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    apply_evt |=> (!flip_done && !flip_pending && scan_pair == $past(shadow_pair)));

  assert_done_retires_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flip_done |-> (!flip_inflight && !flip_pending));

  assert_done_on_eof_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> flip_done);

  assert_disable_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!flip_pending && !flip_inflight && !flip_done && !flip_busy));

endmodule

bind scanflip_top scanflip_chk #(.DW(2 * AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .flip_req(flip_req), .eof(eof),
  .flip_busy(flip_busy), .flip_done(flip_done), .flip_pending(flip_pending),
  .flip_inflight(flip_inflight), .scan_pair(scan_pair), .new_pair(new_pair),
  .shadow_pair(shadow_pair), .act(act), .apply_evt(apply_evt),
  .done_evt(done_evt)
);

// File: tb/tb_scanflip_top.sv
module tb_scanflip_top;

  localparam int CEIL_M1 = 0;
  localparam int PERIOD  = 1000;
  localparam int WINDOW  = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic        flip_req = 1'b0;
  logic [31:0] origin = '0;
  logic [31:0] offset = '0;
  logic [15:0] pitch = '0;
  logic [11:0] x_pan = '0;
  logic [11:0] y_pan = '0;
  logic [2:0]  pix_bytes = '0;
  logic [11:0] lines = '0;
  logic        eof = 1'b0;
  logic [23:0] frame_period = 24'(PERIOD);
  logic [23:0] safe_window = 24'(WINDOW);
  logic [63:0] scan_pair;
  logic        flip_pending, flip_inflight, flip_busy, flip_done;

  always #10 clk = ~clk;  // 50 MHz

  scanflip_top #(.CEIL_M1(CEIL_M1)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .flip_req(flip_req),
    .origin(origin), .offset(offset), .pitch(pitch), .x_pan(x_pan),
    .y_pan(y_pan), .pix_bytes(pix_bytes), .lines(lines), .eof(eof),
    .frame_period(frame_period), .safe_window(safe_window),
    .scan_pair(scan_pair), .flip_pending(flip_pending),
    .flip_inflight(flip_inflight), .flip_busy(flip_busy), .flip_done(flip_done)
  );

  int n_vec = 0, n_bad = 0;      // main process
  int m_vec = 0, m_bad = 0;      // monitor
  int w_bad = 0;                 // watchdog
  bit finished = 1'b0;
  logic [63:0] exp_q[$];
  logic [63:0] prev_pair = '0;

  // Independent address model (64-bit arithmetic, truncated)
  function automatic logic [63:0] model_pair();
    longint unsigned b, c;
    b = longint'(origin) + longint'(offset) + longint'(y_pan) * longint'(pitch)
        + longint'(x_pan) * longint'(pix_bytes);
    b = b & 64'hFFFF_FFFF;
    c = (b + longint'(lines) * longint'(pitch) - longint'(CEIL_M1)) & 64'hFFFF_FFFF;
    return {c[31:0], b[31:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic geo(input logic [31:0] o, input logic [31:0] f, input logic [15:0] p,
                     input logic [11:0] x, input logic [11:0] y, input logic [2:0] bp,
                     input logic [11:0] n);
    origin = o; offset = f; pitch = p; x_pan = x; y_pan = y; pix_bytes = bp; lines = n;
  endtask

  // Called at a negedge; returns at the negedge after the sampling edge
  task automatic do_req();
    flip_req = 1'b1;
    @(negedge clk);
    flip_req = 1'b0;
  endtask

  task automatic do_eof();
    eof = 1'b1;
    @(negedge clk);
    eof = 1'b0;
  endtask

  // request sampled k cycles after the last eof edge
  task automatic req_after_eof(input int k);
    do_eof();
    repeat (k - 1) @(negedge clk);
    do_req();
  endtask

  // Monitor: every change of scan_pair must match the next expected item
  always @(negedge clk) begin
    if (rst_n && !finished && scan_pair !== prev_pair) begin
      m_vec++;
      if (exp_q.size() == 0) begin
        m_bad++;
        $display("FAIL R3: unexpected pair change actual %h expected %h", scan_pair, prev_pair);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        if (scan_pair !== e) begin
          m_bad++;
          $display("FAIL R1/R2: pair actual %h expected %h", scan_pair, e);
        end
      end
      prev_pair = scan_pair;
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==",
             n_vec + m_vec, n_bad + m_bad + w_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      w_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    logic [63:0] pa;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scan_pair == 64'd0, "R3 reset pair", scan_pair, 64'd0);
    chk({flip_pending, flip_inflight, flip_busy, flip_done} == 4'b0, "R3 reset flags",
        {flip_pending, flip_inflight, flip_busy, flip_done}, 4'b0);

    // R6/R1/R2: immediate flip far from frame end
    geo(32'h8000_0000, 0, 16'd1600, 0, 0, 3'd2, 12'd480);
    pa = model_pair(); exp_q.push_back(pa);
    req_after_eof(10);
    chk(scan_pair == pa, "R6 immediate load", scan_pair, pa);
    chk(!flip_pending && flip_inflight, "R6 not pending", {flip_pending, flip_inflight}, 2'b01);

    // R4: second request while in flight
    geo(32'h1234_0000, 0, 16'd64, 1, 1, 3'd1, 12'd8);
    do_req();
    chk(flip_busy == 1'b1, "R4 busy pulse", flip_busy, 1);
    chk(flip_inflight && !flip_pending, "R4 state kept", {flip_pending, flip_inflight}, 2'b01);
    @(negedge clk);
    chk(flip_busy == 1'b0, "R4 busy one cycle", flip_busy, 0);

    // R8: completion at next eof
    do_eof();
    chk(flip_done == 1'b1, "R8 done after eof", flip_done, 1);
    chk(!flip_inflight, "R8 inflight cleared", flip_inflight, 0);
    @(negedge clk);
    chk(flip_done == 1'b0, "R8 done one cycle", flip_done, 0);

    // R5/R9 boundary: elapsed + window == period -> immediate
    geo(32'h1000_0000, 32'h40, 16'd5120, 12'd17, 12'd33, 3'd4, 12'd720);
    pa = model_pair(); exp_q.push_back(pa);
    req_after_eof(PERIOD - WINDOW);
    chk(!flip_pending && scan_pair == pa, "R5 boundary immediate", scan_pair, pa);
    do_eof();
    chk(flip_done == 1'b1, "R8 done pattern 2", flip_done, 1);

    // R5/R7: one cycle later -> deferred
    geo(32'hFFFF_F000, 32'h100, 16'd64, 12'd3, 12'd2, 3'd3, 12'd100);
    pa = model_pair();
    req_after_eof(PERIOD - WINDOW + 1);
    chk(flip_pending == 1'b1, "R5 deferred pending", flip_pending, 1);
    exp_q.push_back(pa);
    do_eof();
    chk(scan_pair == pa, "R7 applied at eof (wraps)", scan_pair, pa);
    chk(flip_done == 1'b0, "R7 no done on apply", flip_done, 0);
    chk(!flip_pending && flip_inflight, "R7 state after apply", {flip_pending, flip_inflight}, 2'b01);
    repeat (5) @(negedge clk);
    do_eof();
    chk(flip_done == 1'b1, "R7 done next eof", flip_done, 1);

    // R9: request long after the last stamp is deferred
    geo(32'h2000_0000, 0, 16'd2048, 12'd100, 12'd0, 3'd4, 12'd600);
    pa = model_pair();
    do_eof();
    repeat (PERIOD + 200) @(negedge clk);
    do_req();
    chk(flip_pending == 1'b1, "R9 stale stamp defers", flip_pending, 1);
    exp_q.push_back(pa);
    do_eof();
    chk(scan_pair == pa && !flip_done, "R9 applied at eof", scan_pair, pa);
    do_eof();
    chk(flip_done == 1'b1, "R9 done following eof", flip_done, 1);

    // R10: disable drops a parked flip
    geo(32'h3000_0000, 32'h8, 16'd320, 12'd5, 12'd7, 3'd2, 12'd240);
    req_after_eof(950);
    chk(flip_pending == 1'b1, "R10 parked before disable", flip_pending, 1);
    enable = 1'b0;
    @(negedge clk);
    chk(!flip_pending && !flip_inflight, "R10 cleared", {flip_pending, flip_inflight}, 2'b00);
    do_req();
    chk(!flip_busy && !flip_pending && !flip_inflight, "R10 request ignored",
        {flip_busy, flip_pending, flip_inflight}, 3'b000);
    enable = 1'b1;
    pa = scan_pair;
    do_eof();
    chk(scan_pair == pa && !flip_done, "R10 no stale apply", scan_pair, pa);

    // R10: after re-enable a new request is accepted
    geo(32'h4000_0000, 0, 16'd1280, 12'd1, 12'd1, 3'd1, 12'd16);
    pa = model_pair(); exp_q.push_back(pa);
    do_req();
    chk(!flip_busy && scan_pair == pa, "R10 accepted after enable", scan_pair, pa);
    do_eof();
    chk(flip_done == 1'b1, "R8 done after re-enable", flip_done, 1);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected pairs seen", 64'(exp_q.size()), 0);
    summary();
  end

endmodule